// File: doc/BRIEF.md
# Banked Register File with Flag Word

This block stores the architectural register state of a small 16-bit controller core. There are eight registers: a stack pointer, four general-purpose registers, a base pointer, a status register and a program counter. A second copy of the four general registers sits in a shadow bank. A 16-bit flag word holds the mode and interrupt-control fields. Software packs and unpacks this word through a dedicated port. The block has no decoder and no memory interface. The execution pipeline around it reads operands through two combinational ports and writes results through one write port.

Changing the bank-select field of the flag word exchanges the live general registers with the shadow bank in a single clock edge. Interrupt entry and exit can therefore swap working sets without any copy loop. The status register serves three purposes. It is a normal register. Its top six bits form a data-segment field. Its bottom six bits extend the program counter to a 22-bit program address. The general registers at indices 4 and 3 are also presented as one 32-bit pair.

Top module: `core_regbank`

## Requirements
- R1: After a synchronous reset, all eight registers and all four shadow registers read 0. The flag word reads 16'h0808, meaning fir_mv (bit 11) is 1, priority (bits 3:0) is 8, and every other field is 0.
- R2: Both read ports return the register selected by their 3-bit index, combinationally. The index map is 0 stack pointer, 1 to 4 general registers, 5 base pointer, 6 status, 7 program counter.
- R3: With wr_en high, wr_data is stored into register wr_idx on the rising clock edge. A read of that register in the same cycle still returns the old value.
- R4: The flag word has these fields: bit 14 accumulate mode, bit 13 bank select, bit 12 fraction mode, bit 11 fir_mv, bits 10:7 a 4-bit shift field, bit 6 fast-interrupt enable, bit 5 interrupt enable, bit 4 nesting enable, bits 3:0 priority. A write stores bits 14:0. Bit 15 always reads 0.
- R5: A flag-word write whose bit 13 differs from the current bank bit exchanges registers 1 to 4 with the four shadow registers on that edge. Registers 0, 5, 6 and 7 are unaffected.
- R6: A flag-word write whose bit 13 equals the current bank bit leaves registers 1 to 4 and the shadow bank unchanged.
- R7: When a flag-word write and a general write to index 1 to 4 occur in the same cycle, the exchange happens first. The written value then lands in the newly live register, and the shadow bank receives the old live values unmodified.
- R8: seg_out shows status bits 15:10. A segment write replaces those bits and keeps status bits 9:0. If a general write to index 6 happens in the same cycle, bits 15:10 come from seg_wr_data and bits 9:0 come from wr_data.
- R9: prog_addr is {status[5:0], program counter}, 22 bits wide.
- R10: pair_out is {register 4, register 3}, with register 4 as the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 3 | General write register index |
| wr_data | input | 16 | General write data |
| fw_wr_en | input | 1 | Flag-word write enable |
| fw_wr_data | input | 16 | Flag-word write data |
| fw_rd_data | output | 16 | Current flag word |
| seg_wr_en | input | 1 | Segment field write enable |
| seg_wr_data | input | 6 | New segment field value |
| seg_out | output | 6 | Current segment field |
| pair_out | output | 32 | Registers 4 and 3 joined as one 32-bit value |
| prog_addr | output | 22 | Extended program address |

## Verification
The hardest case to reach is a flag-word write that flips the bank while a general write targets one of registers 1 to 4. The ports only ever show the live bank. To check that the shadow bank kept the old live values untouched, the stimulus has to flip the bank a second time and read the registers back. The bench first loads distinct values into both banks. It then issues the combined write and flips back. From each read it tells apart a lost shadow value, a value written to the wrong bank and a missed exchange. For the same reason, a non-flipping flag write is followed by a flip, so that the shadow contents become visible.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int FW_W   = 16;
  localparam int SP_IDX = 0;
  localparam int SR_IDX = 6;
  localparam int PC_IDX = 7;
  localparam int LO_IDX = 3;
  localparam int HI_IDX = 4;

  // Field order sets the bit positions: rsvd is bit 15, pri is bits 3:0.
  typedef struct packed {
    logic       rsvd;
    logic       acc_mode;
    logic       bank;
    logic       frac_mode;
    logic       fir_mv;
    logic [3:0] shift_fld;
    logic       fiq_en;
    logic       irq_en;
    logic       nest_en;
    logic [3:0] pri;
  } flag_word_t;

  localparam flag_word_t FW_RESET = '{
    rsvd: 1'b0, acc_mode: 1'b0, bank: 1'b0, frac_mode: 1'b0, fir_mv: 1'b1,
    shift_fld: 4'd0, fiq_en: 1'b0, irq_en: 1'b0, nest_en: 1'b0, pri: 4'd8
  };
endpackage

// File: rtl/regbank_flags.sv
module regbank_flags
  import regbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            fw_wr_en,
  input  logic [FW_W-1:0] fw_wr_data,
  output flag_word_t      flags_q,
  output logic            bank_flip
);
  flag_word_t incoming;

  always_comb begin
    incoming      = flag_word_t'(fw_wr_data);
    // The top bit is not stored; it always reads back as zero.
    incoming.rsvd = fw_wr_data[FW_W-1] & 1'b0;
  end

  assign bank_flip = fw_wr_en && (incoming.bank != flags_q.bank);

  always_ff @(posedge clk) begin
    if (rst)           flags_q <= FW_RESET;
    else if (fw_wr_en) flags_q <= incoming;
  end
endmodule

// File: rtl/regbank_gen.sv
module regbank_gen #(
  parameter int DW    = 16,
  parameter int NGEN  = 4,
  parameter int IDX_W = 3,
  parameter int BASE  = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      swap,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [DW-1:0]             wr_data,
  output logic [NGEN-1:0][DW-1:0]   live_q,
  output logic [NGEN-1:0][DW-1:0]   shadow_q
);
  for (genvar k = 0; k < NGEN; k++) begin : g_slot
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE + k);
    logic hit;
    assign hit = wr_en && (wr_idx == MY_IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        live_q[k]   <= '0;
        shadow_q[k] <= '0;
      end else begin
        if (swap) begin
          live_q[k]   <= shadow_q[k];
          shadow_q[k] <= live_q[k];
        end
        // A same-cycle write overrides the swapped-in value: it lands in the new bank.
        if (hit) live_q[k] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/regbank_sys.sv
module regbank_sys #(
  parameter int DW     = 16,
  parameter int NGEN   = 4,
  parameter int IDX_W  = 3,
  parameter int SEG_W  = 6,
  parameter int SR_POS = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic                    seg_wr_en,
  input  logic [SEG_W-1:0]        seg_wr_data,
  output logic [(1<<IDX_W)-NGEN-1:0][DW-1:0] sys_q
);
  localparam int NSYS    = (1 << IDX_W) - NGEN;
  localparam int SEG_LSB = DW - SEG_W;

  for (genvar s = 0; s < NSYS; s++) begin : g_sys
    localparam int MY_IDX = (s == 0) ? 0 : s + NGEN;
    logic hit;
    logic [DW-1:0] nxt;
    assign hit = wr_en && (wr_idx == IDX_W'(MY_IDX));

    if (MY_IDX == SR_POS) begin : g_status
      always_comb begin
        nxt = hit ? wr_data : sys_q[s];
        if (seg_wr_en) nxt[DW-1:SEG_LSB] = seg_wr_data;
      end
    end else begin : g_plain
      assign nxt = hit ? wr_data : sys_q[s];
    end

    always_ff @(posedge clk) begin
      if (rst) sys_q[s] <= '0;
      else     sys_q[s] <= nxt;
    end
  end
endmodule

// File: rtl/core_regbank.sv
module core_regbank
  import regbank_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IDX_W = 3,
  parameter int SEG_W = 6,
  parameter int HI_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     rd_a_idx,
  output logic [DW-1:0]        rd_a_data,
  input  logic [IDX_W-1:0]     rd_b_idx,
  output logic [DW-1:0]        rd_b_data,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic                 fw_wr_en,
  input  logic [DW-1:0]        fw_wr_data,
  output logic [DW-1:0]        fw_rd_data,
  input  logic                 seg_wr_en,
  input  logic [SEG_W-1:0]     seg_wr_data,
  output logic [SEG_W-1:0]     seg_out,
  output logic [2*DW-1:0]      pair_out,
  output logic [HI_W+DW-1:0]   prog_addr
);
  localparam int NREG = 1 << IDX_W;
  localparam int NGEN = 4;
  localparam int NSYS = NREG - NGEN;

  flag_word_t                 flags_q;
  logic                       bank_flip;
  logic [NGEN-1:0][DW-1:0]    gen_live;
  logic [NGEN-1:0][DW-1:0]    gen_shadow;
  logic [NSYS-1:0][DW-1:0]    sys_q;
  logic [DW-1:0]              all_regs [NREG];

  regbank_flags u_flags (
    .clk(clk), .rst(rst), .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
    .flags_q(flags_q), .bank_flip(bank_flip)
  );

  regbank_gen #(.DW(DW), .NGEN(NGEN), .IDX_W(IDX_W), .BASE(1)) u_gen (
    .clk(clk), .rst(rst), .swap(bank_flip), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .live_q(gen_live), .shadow_q(gen_shadow)
  );

  regbank_sys #(.DW(DW), .NGEN(NGEN), .IDX_W(IDX_W), .SEG_W(SEG_W), .SR_POS(SR_IDX)) u_sys (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .seg_wr_en(seg_wr_en), .seg_wr_data(seg_wr_data), .sys_q(sys_q)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_map
    if (i >= 1 && i <= NGEN) begin : g_gen
      assign all_regs[i] = gen_live[i-1];
    end else if (i == 0) begin : g_sp
      assign all_regs[i] = sys_q[0];
    end else begin : g_sys
      assign all_regs[i] = sys_q[i-NGEN];
    end
  end

  assign rd_a_data  = all_regs[rd_a_idx];
  assign rd_b_data  = all_regs[rd_b_idx];
  assign fw_rd_data = DW'(flags_q);
  assign seg_out    = all_regs[SR_IDX][DW-1 -: SEG_W];
  assign prog_addr  = {all_regs[SR_IDX][HI_W-1:0], all_regs[PC_IDX]};
  assign pair_out   = {all_regs[HI_IDX], all_regs[LO_IDX]};
endmodule

// File: rtl/core_regbank_chk.sv
module core_regbank_chk #(
  parameter int DW    = 16,
  parameter int IDX_W = 3,
  parameter int SEG_W = 6,
  parameter int HI_W  = 6,
  parameter int NGEN  = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [IDX_W-1:0]         wr_idx,
  input logic                     fw_wr_en,
  input logic [DW-1:0]            fw_wr_data,
  input logic [DW-1:0]            fw_rd_data,
  input logic                     seg_wr_en,
  input logic [SEG_W-1:0]         seg_wr_data,
  input logic [SEG_W-1:0]         seg_out,
  input logic [HI_W+DW-1:0]       prog_addr,
  input logic [NGEN-1:0][DW-1:0]  gen_live,
  input logic [NGEN-1:0][DW-1:0]  gen_shadow
);
  localparam logic [IDX_W-1:0] SR_I = IDX_W'(6);

  // R1
  a_r1_reset_flags: assert property (@(posedge clk) rst |=> fw_rd_data == 16'h0808);

  // R4
  a_r4_flag_readback: assert property (@(posedge clk) disable iff (rst)
    fw_wr_en |=> fw_rd_data == {1'b0, $past(fw_wr_data[DW-2:0])});

  // R5
  a_r5_bank_exchange: assert property (@(posedge clk) disable iff (rst)
    (fw_wr_en && (fw_wr_data[13] != fw_rd_data[13]) && !wr_en)
    |=> (gen_live == $past(gen_shadow)) && (gen_shadow == $past(gen_live)));

  // R6
  a_r6_no_exchange: assert property (@(posedge clk) disable iff (rst)
    (fw_wr_en && (fw_wr_data[13] == fw_rd_data[13]) && !wr_en)
    |=> (gen_live == $past(gen_live)) && (gen_shadow == $past(gen_shadow)));

  // R8
  a_r8_seg_update: assert property (@(posedge clk) disable iff (rst)
    seg_wr_en |=> seg_out == $past(seg_wr_data));

  // R8, R9
  a_r8_low_kept: assert property (@(posedge clk) disable iff (rst)
    (seg_wr_en && !(wr_en && wr_idx == SR_I))
    |=> prog_addr[HI_W+DW-1:DW] == $past(prog_addr[HI_W+DW-1:DW]));
endmodule

bind core_regbank core_regbank_chk #(.DW(DW), .IDX_W(IDX_W), .SEG_W(SEG_W), .HI_W(HI_W), .NGEN(4)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .fw_wr_en(fw_wr_en),
  .fw_wr_data(fw_wr_data), .fw_rd_data(fw_rd_data), .seg_wr_en(seg_wr_en),
  .seg_wr_data(seg_wr_data), .seg_out(seg_out), .prog_addr(prog_addr),
  .gen_live(gen_live), .gen_shadow(gen_shadow)
);

// File: tb/core_regbank_test.sv
`timescale 1ns/10ps
module core_regbank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0, fw_wr_data = '0, fw_rd_data;
  logic wr_en = 1'b0, fw_wr_en = 1'b0, seg_wr_en = 1'b0;
  logic [5:0] seg_wr_data = '0, seg_out;
  logic [31:0] pair_out;
  logic [21:0] prog_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] m_reg [8];
  logic [15:0] m_sh  [4];
  logic [15:0] m_fw;

  always #2 clk = ~clk;

  core_regbank uut (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
    .fw_rd_data(fw_rd_data), .seg_wr_en(seg_wr_en), .seg_wr_data(seg_wr_data),
    .seg_out(seg_out), .pair_out(pair_out), .prog_addr(prog_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    for (int i = 0; i < 4; i++) m_sh[i] = '0;
    m_fw = 16'h0808;
  endtask

  // One clock cycle of stimulus; the model follows the requirement text.
  task automatic step(input bit we, input logic [2:0] wi, input logic [15:0] wd,
                      input bit fe, input logic [15:0] fd,
                      input bit se, input logic [5:0] sd);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    fw_wr_en = fe; fw_wr_data = fd;
    seg_wr_en = se; seg_wr_data = sd;
    if (fe) begin
      if (fd[13] != m_fw[13])
        for (int k = 0; k < 4; k++) begin
          logic [15:0] t;
          t = m_reg[k+1]; m_reg[k+1] = m_sh[k]; m_sh[k] = t;
        end
      m_fw = {1'b0, fd[14:0]};
    end
    if (we) m_reg[wi] = wd;
    if (se) m_reg[6][15:10] = sd;
    @(posedge clk);
    #1;
    wr_en = 1'b0; fw_wr_en = 1'b0; seg_wr_en = 1'b0;
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd_a_idx = 3'(i); rd_b_idx = 3'(7 - i);
      #0.2;
      chk({tag, "/R2 port A"}, {16'h0, rd_a_data}, {16'h0, m_reg[i]});
      chk({tag, "/R2 port B"}, {16'h0, rd_b_data}, {16'h0, m_reg[7-i]});
    end
    chk({tag, "/R4 flag word"}, {16'h0, fw_rd_data}, {16'h0, m_fw});
    chk({tag, "/R8 segment"}, {26'h0, seg_out}, {26'h0, m_reg[6][15:10]});
    chk({tag, "/R9 prog addr"}, {10'h0, prog_addr}, {10'h0, m_reg[6][5:0], m_reg[7]});
    chk({tag, "/R10 pair"}, pair_out, {m_reg[4], m_reg[3]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check_all("R1");
    // R1: shadow bank cleared too, seen after a flip
    step(0, 0, 0, 1, 16'h2808, 0, 0);
    check_all("R1 shadow");
    step(0, 0, 0, 1, 16'h0808, 0, 0);

    // R3: sweep every index with a distinct pattern
    for (int i = 0; i < 8; i++) begin
      step(1, 3'(i), 16'h1111 * 16'(i + 1) ^ 16'h8421, 0, 0, 0, 0);
      check_all("R3 sweep");
    end

    // R3: same-cycle read returns old value
    @(negedge clk);
    wr_en = 1; wr_idx = 3'd5; wr_data = 16'hBEEF; rd_a_idx = 3'd5;
    #0.5 chk("R3 old before edge", {16'h0, rd_a_data}, {16'h0, m_reg[5]});
    @(posedge clk); #1 wr_en = 0;
    m_reg[5] = 16'hBEEF;
    chk("R3 new after edge", {16'h0, rd_a_data}, 32'h0000BEEF);

    // R4, R6: flag patterns with bank bit held at 0
    for (int p = 0; p < 16; p++) begin
      logic [15:0] fv;
      fv = (16'h9D37 * 16'(p + 3)) & ~16'h2000;
      step(0, 0, 0, 1, fv, 0, 0);
      check_all("R6 no exchange");
    end

    // R5: flip, load bank 1, flip back, flip again
    step(0, 0, 0, 1, 16'h2000, 0, 0);
    check_all("R5 flip to 1");
    for (int k = 1; k <= 4; k++) step(1, 3'(k), 16'hA000 + 16'(k), 0, 0, 0, 0);
    step(0, 0, 0, 1, 16'h0055, 0, 0);
    check_all("R5 flip to 0");
    chk("R5 R2 restored", {16'h0, m_reg[2]}, {16'h0, 16'h1111 * 16'd3 ^ 16'h8421});
    step(0, 0, 0, 1, 16'hFFFF, 0, 0);
    check_all("R5 flip via all-ones");

    // R7: flip with concurrent general write, then flip back to expose shadows
    step(1, 3'd2, 16'h5A5A, 1, 16'h0000, 0, 0);
    check_all("R7 write lands in new bank");
    step(0, 0, 0, 1, 16'h2000, 0, 0);
    check_all("R7 shadow untouched");
    step(1, 3'd3, 16'hC3C3, 1, 16'h2001, 0, 0);
    check_all("R7 no flip plus write");
    step(0, 0, 0, 1, 16'h0000, 0, 0);
    check_all("R7 shadow after no-flip write");

    // R8, R9: all segment values over a fixed low part
    step(1, 3'd6, 16'h0155, 0, 0, 0, 0);
    for (int s = 0; s < 64; s++) begin
      step(0, 0, 0, 0, 0, 1, 6'(s));
      chk("R8 low bits kept", {22'h0, rd_a_data[9:0] & 10'h0 | m_reg[6][9:0]}, {22'h0, 10'h155});
      check_all("R8 segment sweep");
    end
    step(1, 3'd6, 16'hFFC0 | 16'h002A, 0, 0, 1, 6'h15);
    check_all("R8 seg and status same cycle");

    // R9, R10: program counter and pair
    for (int q = 0; q < 8; q++) begin
      step(1, 3'd7, 16'hF00D ^ 16'(q * 977), 0, 0, 0, 0);
      step(1, 3'd6, 16'(q * 9), 0, 0, 0, 0);
      step(1, 3'(3 + (q % 2)), 16'h7E00 + 16'(q), 0, 0, 0, 0);
      check_all("R9 R10 sweep");
    end

    finish_run();
  end
endmodule